// File: doc/BRIEF.md
# Film cadence lock controller

This unit decides, once per video field, whether a motion-adaptive deinterlacer should weave fields back together as film (reverse telecine) or stay in video mode. The upstream cadence recogniser and the per-pixel difference logic report three numbers at the end of every field: whether a film cadence was seen, how many pixels show that cadence, and the total motion of the field. The controller qualifies the field, counts consecutive qualified fields and raises a reverse-telecine enable only after a programmable settling delay. It also watches for a sudden jump in motion, such as a cut or a bad edit, and throws the cadence state away when one occurs.

A field is qualified when the cadence strobe is high and the pixel count reaches a programmable floor. The motion jump test compares the new field's motion with the previous field's motion scaled by a power of two, using a shift rather than a multiplier. Three thresholds are written through a small address/data/write-enable port. All per-field inputs are taken on a one-cycle `field_end` strobe, and the three outputs change on the clock edge that samples it and then hold until the next one.

Top module: `film_lock_ctrl`

## Requirements
- R1: After the synchronous active-high reset, `film_lock`, `rt_enable` and `scene_cut` are 0, the settling delay is 5, the pixel floor is 256, the scene shift is 2, and the previous-field motion is marked invalid.
- R2: The outputs change only on the clock edge at which `field_end` is 1; on every other edge they hold their value.
- R3: A field is qualified when `cadence_det` is 1 and `cad_pixels` is greater than or equal to the pixel floor (unsigned). On a qualified field without a scene cut `film_lock` becomes 1; on any other field it becomes 0.
- R4: With settling delay D (0 to 31), `rt_enable` becomes 1 on the (D+1)th consecutive qualified field, so D = 0 engages on the first one; D below 5 is legal.
- R5: A field that is not qualified clears `rt_enable` and restarts the qualified-field count from zero, including when it occurs before the delay has expired.
- R6: When a previous field exists since reset, `field_motion` is non-zero and `field_motion` is at least the previous field's motion shifted left by the scene shift, `scene_cut` becomes 1 for that field and `film_lock`, `rt_enable` and the count are cleared even if the field is qualified; otherwise `scene_cut` becomes 0.
- R7: The shifted comparison is done at full width, so a scene shift of 15 with a full-scale previous motion never wraps and never reports a cut for an equal or smaller motion.
- R8: A write with `cfg_we` = 1 at word address 16 loads the settling delay from `cfg_wdata[4:0]`, at 17 the pixel floor from `cfg_wdata[31:0]`, at 19 the scene shift from `cfg_wdata[3:0]`; writes to any other address change nothing.
- R9: Once `rt_enable` is 1 it stays 1 for every following qualified field without a scene cut, whatever the delay register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Threshold register write enable |
| cfg_addr | input | 5 | Threshold register word address |
| cfg_wdata | input | 32 | Threshold register write data |
| field_end | input | 1 | One-cycle strobe at the end of each field |
| cadence_det | input | 1 | Cadence seen in this field |
| cad_pixels | input | 32 | Number of pixels showing the cadence |
| field_motion | input | 24 | Total motion measure of this field |
| film_lock | output | 1 | Cadence lock held |
| rt_enable | output | 1 | Reverse telecine enabled |
| scene_cut | output | 1 | Scene change or bad edit seen in the last field |

## Verification
Every output is one register away from `field_end`: the bench raises the strobe half a cycle before a rising edge, drops it at the following falling edge and compares all three outputs there against the model, which has just been advanced by the same field. Threshold writes take effect on the edge that samples `cfg_we`, so the model applies them before the next field is driven. Between fields the bench idles for a random number of cycles and checks at the end that nothing moved, which covers the hold behaviour.

// File: rtl/flc_pkg.sv
package flc_pkg;

   // Word addresses of the threshold registers
   localparam int unsigned ADR_DELAY = 16;
   localparam int unsigned ADR_MINPX = 17;
   localparam int unsigned ADR_SHIFT = 19;

   // Lock state: no lock, locked and settling, reverse telecine active
   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_WAIT = 2'd1,
      LK_FILM = 2'd2
   } lock_state_t;

endpackage

// File: rtl/flc_regs.sv
module flc_regs #(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DLY_W   = 5,
   parameter int unsigned PIX_W   = 32,
   parameter int unsigned SH_W    = 4,
   parameter int unsigned DLY_RST = 5,
   parameter int unsigned PIX_RST = 256,
   parameter int unsigned SH_RST  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DLY_W-1:0]  delay,
   output logic [PIX_W-1:0]  min_pix,
   output logic [SH_W-1:0]   shift
);
   import flc_pkg::*;

   localparam logic [ADDR_W-1:0] A_DLY = ADDR_W'(ADR_DELAY);
   localparam logic [ADDR_W-1:0] A_PIX = ADDR_W'(ADR_MINPX);
   localparam logic [ADDR_W-1:0] A_SH  = ADDR_W'(ADR_SHIFT);

   generate
      if (DLY_W > DATA_W || PIX_W > DATA_W || SH_W > DATA_W) begin : g_bad_width
         $error("flc_regs: a field is wider than the write data");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("flc_regs: address too narrow for the register map");
      end
   endgenerate

   logic sel_dly, sel_pix, sel_sh;
   assign sel_dly = we && (addr == A_DLY);
   assign sel_pix = we && (addr == A_PIX);
   assign sel_sh  = we && (addr == A_SH);

   always_ff @(posedge clk) begin
      if (rst) begin
         delay   <= DLY_W'(DLY_RST);
         min_pix <= PIX_W'(PIX_RST);
         shift   <= SH_W'(SH_RST);
      end else begin
         if (sel_dly) delay   <= wdata[DLY_W-1:0];
         if (sel_pix) min_pix <= wdata[PIX_W-1:0];
         if (sel_sh)  shift   <= wdata[SH_W-1:0];
      end
   end

endmodule

// File: rtl/flc_scene_det.sv
module flc_scene_det #(
   parameter int unsigned MOT_W = 24,
   parameter int unsigned SH_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample,
   input  logic [MOT_W-1:0] motion,
   input  logic [SH_W-1:0]  shift,
   output logic             hit
);
   // Wide enough that the largest shift of a full-scale value cannot wrap
   localparam int unsigned WIDE_W = MOT_W + (2 ** SH_W) - 1;

   generate
      if (SH_W > 5) begin : g_bad_shift
         $error("flc_scene_det: shift field too wide for a practical comparator");
      end
   endgenerate

   logic [MOT_W-1:0]  prev_mot;
   logic              prev_ok;
   logic [WIDE_W-1:0] prev_wide;
   logic [WIDE_W-1:0] cur_wide;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_mot <= '0;
         prev_ok  <= 1'b0;
      end else if (sample) begin
         prev_mot <= motion;
         prev_ok  <= 1'b1;
      end
   end

   always_comb begin
      prev_wide = WIDE_W'(prev_mot) << shift;
      cur_wide  = WIDE_W'(motion);
      hit       = prev_ok && (motion != '0) && (cur_wide >= prev_wide);
   end

endmodule

// File: rtl/flc_lock_fsm.sv
module flc_lock_fsm #(
   parameter int unsigned DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic             qualify,
   input  logic             cut,
   input  logic [DLY_W-1:0] delay,
   output logic             lock,
   output logic             rt_en,
   output logic             cut_q
);
   import flc_pkg::*;

   lock_state_t      st, st_nx;
   logic [DLY_W-1:0] cnt, cnt_nx;

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      if (cut || !qualify) begin
         st_nx  = LK_IDLE;
         cnt_nx = '0;
      end else if (st != LK_FILM) begin
         if (cnt >= delay) begin
            st_nx = LK_FILM;
         end else begin
            st_nx  = LK_WAIT;
            cnt_nx = cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= LK_IDLE;
         cnt   <= '0;
         cut_q <= 1'b0;
      end else if (step) begin
         st    <= st_nx;
         cnt   <= cnt_nx;
         cut_q <= cut;
      end
   end

   assign lock  = (st != LK_IDLE);
   assign rt_en = (st == LK_FILM);

endmodule

// File: rtl/film_lock_ctrl.sv
module film_lock_ctrl #(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PIX_W   = 32,
   parameter int unsigned MOT_W   = 24,
   parameter int unsigned DLY_W   = 5,
   parameter int unsigned SH_W    = 4,
   parameter int unsigned DLY_RST = 5,
   parameter int unsigned PIX_RST = 256,
   parameter int unsigned SH_RST  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              field_end,
   input  logic              cadence_det,
   input  logic [PIX_W-1:0]  cad_pixels,
   input  logic [MOT_W-1:0]  field_motion,
   output logic              film_lock,
   output logic              rt_enable,
   output logic              scene_cut
);

   generate
      if (DLY_RST >= (2 ** DLY_W)) begin : g_bad_dly_rst
         $error("film_lock_ctrl: delay reset value does not fit");
      end
      if (SH_RST >= (2 ** SH_W)) begin : g_bad_sh_rst
         $error("film_lock_ctrl: shift reset value does not fit");
      end
   endgenerate

   logic [DLY_W-1:0] r_delay;
   logic [PIX_W-1:0] r_min_pix;
   logic [SH_W-1:0]  r_shift;
   logic             qual, cut_hit;

   flc_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W), .PIX_W(PIX_W),
      .SH_W(SH_W), .DLY_RST(DLY_RST), .PIX_RST(PIX_RST), .SH_RST(SH_RST)
   ) u_regs (
      .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .delay(r_delay), .min_pix(r_min_pix), .shift(r_shift)
   );

   flc_scene_det #(.MOT_W(MOT_W), .SH_W(SH_W)) u_scene (
      .clk(clk), .rst(rst), .sample(field_end), .motion(field_motion),
      .shift(r_shift), .hit(cut_hit)
   );

   assign qual = cadence_det && (cad_pixels >= r_min_pix);

   flc_lock_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk(clk), .rst(rst), .step(field_end), .qualify(qual), .cut(cut_hit),
      .delay(r_delay), .lock(film_lock), .rt_en(rt_enable), .cut_q(scene_cut)
   );

endmodule

// File: rtl/film_lock_ctrl_chk.sv
module film_lock_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic field_end,
   input logic cadence_det,
   input logic film_lock,
   input logic rt_enable,
   input logic scene_cut
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!film_lock && !rt_enable && !scene_cut)); // R1

   AST_HOLD_BETWEEN_FIELDS: assert property (@(posedge clk) disable iff (rst)
      !field_end |=> $stable({film_lock, rt_enable, scene_cut})); // R2

   AST_RT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      rt_enable |-> film_lock); // R4

   AST_LOCK_NEEDS_CADENCE: assert property (@(posedge clk) disable iff (rst)
      (field_end && !cadence_det) |=> (!film_lock && !rt_enable)); // R5

   AST_CUT_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
      scene_cut |-> (!film_lock && !rt_enable)); // R6

endmodule

bind film_lock_ctrl film_lock_ctrl_chk u_chk (
   .clk(clk), .rst(rst), .field_end(field_end), .cadence_det(cadence_det),
   .film_lock(film_lock), .rt_enable(rt_enable), .scene_cut(scene_cut)
);

// File: tb/film_lock_ctrl_test.sv
`timescale 1ns/1ps
module film_lock_ctrl_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        field_end = 1'b0;
   logic        cadence_det = 1'b0;
   logic [31:0] cad_pixels = '0;
   logic [23:0] field_motion = '0;
   logic        film_lock, rt_enable, scene_cut;

   always #2.5 clk = ~clk;

   film_lock_ctrl uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .field_end(field_end), .cadence_det(cadence_det),
      .cad_pixels(cad_pixels), .field_motion(field_motion),
      .film_lock(film_lock), .rt_enable(rt_enable), .scene_cut(scene_cut)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // Reference model state
   int          m_st = 0;   // 0 idle, 1 settling, 2 film
   int          m_cnt = 0;
   int unsigned m_delay = 5, m_sh = 2;
   longint unsigned m_minp = 256, m_prev = 0;
   bit          m_have = 0, m_cut = 0;

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit cut_exp(input bit have, input longint unsigned prev,
                                  input longint unsigned cur, input int unsigned sh);
      return have && (cur != 0) && (cur >= (prev << sh));
   endfunction

   task automatic model_reset();
      m_st = 0; m_cnt = 0; m_delay = 5; m_sh = 2; m_minp = 256;
      m_prev = 0; m_have = 0; m_cut = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_reset();
      check("R1 lock after reset", film_lock, 0);
      check("R1 rt after reset", rt_enable, 0);
      check("R1 cut after reset", scene_cut, 0);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 5'd16) m_delay = d[4:0];
      if (a == 5'd17) m_minp = d;
      if (a == 5'd19) m_sh = d[3:0];
   endtask

   task automatic field(input bit cad, input logic [31:0] pix, input logic [23:0] mot);
      bit c, q;
      @(negedge clk);
      cadence_det = cad; cad_pixels = pix; field_motion = mot; field_end = 1'b1;
      @(negedge clk);
      field_end = 1'b0;
      c = cut_exp(m_have, m_prev, mot, m_sh);
      q = cad && (longint'(pix) >= longint'(m_minp));
      if (c || !q) begin
         m_st = 0; m_cnt = 0;
      end else if (m_st != 2) begin
         if (m_cnt >= int'(m_delay)) m_st = 2;
         else begin m_st = 1; m_cnt++; end
      end
      m_cut = c; m_prev = mot; m_have = 1;
      check("R3 film_lock", film_lock, (m_st != 0));
      check("R4 R9 rt_enable", rt_enable, (m_st == 2));
      check("R6 scene_cut", scene_cut, m_cut);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      check("R2 hold lock", film_lock, (m_st != 0));
      check("R2 hold rt", rt_enable, (m_st == 2));
      check("R2 hold cut", scene_cut, m_cut);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired, actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();

      // R1 R3: default floor 256
      field(1, 255, 10);
      check("R1 R3 floor 255 no lock", film_lock, 0);
      field(1, 256, 10);
      check("R1 R3 floor 256 locks", film_lock, 1);
      // R1 R4: default delay 5, rt on sixth qualified field
      for (int i = 0; i < 4; i++) field(1, 300, 10);
      check("R1 R4 not yet after 5", rt_enable, 0);
      field(1, 300, 10);
      check("R1 R4 engaged on 6th", rt_enable, 1);
      idle(3);
      // R9: raising delay does not drop film
      wr(5'd16, 32'd31);
      field(1, 300, 10);
      check("R9 stays film", rt_enable, 1);

      // R6 R1: default shift 2, 4x jump
      field(1, 300, 100);
      field(1, 300, 399);
      check("R6 399 vs 100 no cut", scene_cut, 0);
      field(1, 300, 1596);
      check("R6 1596 vs 399 cut", scene_cut, 1);
      check("R6 cut drops lock", film_lock, 0);

      // R4: delay 0 engages on first qualified field
      wr(5'd16, 32'd0);
      field(0, 300, 1000);
      field(1, 300, 1000);
      check("R4 delay 0 immediate", rt_enable, 1);

      // R5: drop before delay expires restarts count
      wr(5'd16, 32'd3);
      field(0, 300, 1000);
      field(1, 300, 1000); field(1, 300, 1000);
      field(0, 300, 1000);
      check("R5 drop clears lock", film_lock, 0);
      for (int i = 0; i < 3; i++) field(1, 300, 1000);
      check("R5 restarted not yet", rt_enable, 0);
      field(1, 300, 1000);
      check("R5 engaged after restart", rt_enable, 1);

      // R8: unmapped writes ignored, floor write applies
      wr(5'd18, 32'd0); wr(5'd20, 32'hFFFF_FFFF); wr(5'd0, 32'd1);
      field(0, 0, 1000);
      for (int i = 0; i < 3; i++) field(1, 300, 1000);
      check("R8 delay kept at 3", rt_enable, 0);
      field(1, 300, 1000);
      check("R8 delay 3 engages", rt_enable, 1);
      wr(5'd17, 32'hFFFF_FFFF);
      field(1, 32'hFFFF_FFFE, 1000);
      check("R8 floor max blocks", film_lock, 0);
      field(1, 32'hFFFF_FFFF, 1000);
      check("R8 floor max equal locks", film_lock, 1);
      wr(5'd17, 32'd256);

      // R7: shift 15 at full scale
      wr(5'd19, 32'd15);
      field(1, 300, 24'hFF_FFFF);
      field(1, 300, 24'hFF_FFFF);
      check("R7 no wrap full scale", scene_cut, 0);
      field(1, 300, 24'd1);
      field(1, 300, 24'd32767);
      check("R7 below 2^15", scene_cut, 0);
      field(1, 300, 24'd1);
      field(1, 300, 24'd32768);
      check("R7 at 2^15", scene_cut, 1);
      wr(5'd19, 32'd0);
      field(1, 300, 24'd50);
      field(1, 300, 24'd50);
      check("R6 shift 0 equal cuts", scene_cut, 1);

      // R1 R6: first field after reset never a cut
      do_reset();
      field(1, 300, 24'hFF_FFFF);
      check("R6 first field no cut", scene_cut, 0);

      // Constrained random phase
      for (int i = 0; i < 800; i++) begin
         int unsigned r = $urandom_range(0, 99);
         bit cad;
         logic [31:0] pix;
         logic [23:0] mot;
         if (r < 4) wr(5'd16, $urandom_range(0, 8));
         else if (r < 6) wr(5'd19, $urandom_range(0, 4));
         else if (r < 8) wr(5'd17, $urandom_range(200, 320));
         else if (r < 10) wr(5'($urandom_range(0, 31)), $urandom);
         cad = ($urandom_range(0, 9) != 0);
         pix = $urandom_range(150, 400);
         mot = ($urandom_range(0, 19) == 0) ? 24'($urandom_range(0, 24'hFF_FFFF))
                                             : 24'($urandom_range(0, 300));
         field(cad, pix, mot);
         if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4));
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule